// File: doc/BRIEF.md
# Register Port Arbiter

This block sits between one read port and one write port of a register file and the function units that compete for them. Each function unit raises a request on the channel it needs. A fixed-priority picker chooses exactly one unit for each channel in the same cycle, and the lowest index wins.

On the read channel, the register file's output data goes to every unit. Only the chosen unit sees its valid strobe, and the chosen unit's address is steered to the register file. On the write channel, the chosen unit's address and data are folded onto the single write port through an AND-OR mux driven by the one-hot grant. The chosen unit receives an acknowledge.

A unit that is not chosen keeps its request raised and is served in a later cycle. The set of contending units is fixed when the block is elaborated, with `NUM_UNITS` between 1 and 8. The block holds no state: reset only qualifies the checks.

Top module: `regport_arbiter`

## Requirements
- R1: On each channel, the grant vector (`rd_valid` for reads, `wr_ack` for writes) has at most one bit set, and a bit is set only for a unit whose request is high.
- R2: When several units request the same channel, the unit with the lowest index is granted.
- R3: When at least one unit requests a channel, exactly one unit is granted in that same cycle. With no request, no unit is granted.
- R4: The register file read data `rf_rd_data` appears unchanged on every unit's slice of `rd_data_fu` (unit i occupies bits [i*DATA_W +: DATA_W]), whether or not that unit is granted.
- R5: `rd_valid[i]` is high in exactly the cycles where unit i holds the read grant. A unit that loses keeps its request and is granted once every lower-index request has dropped.
- R6: `rf_rd_en` is high whenever any read request is high. `rf_rd_addr` equals the granted unit's address (unit i occupies `rd_addr[i*ADDR_W +: ADDR_W]`).
- R7: `rf_wr_en` is high exactly when some write request is high. `rf_wr_addr` and `rf_wr_data` then equal the granted unit's slice of `wr_addr` and `wr_data`.
- R8: With no write request, `rf_wr_en`, `rf_wr_addr` and `rf_wr_data` are all zero.
- R9: With `NUM_UNITS` = 1, the single unit's request passes straight through to its grant on both channels.
- R10: The read and write channels arbitrate independently: a grant on one never depends on the requests of the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock used to sample the checks |
| rst_n | input | 1 | Synchronous active-low reset; checks are idle while low |
| rd_req | input | NUM_UNITS | Read request, one bit per unit |
| rd_addr | input | NUM_UNITS*ADDR_W | Read address per unit, packed |
| rd_data_fu | output | NUM_UNITS*DATA_W | Read data broadcast, one copy per unit |
| rd_valid | output | NUM_UNITS | One-hot read grant / data valid per unit |
| rf_rd_en | output | 1 | Read enable to the register file |
| rf_rd_addr | output | ADDR_W | Read address to the register file |
| rf_rd_data | input | DATA_W | Read data from the register file |
| wr_req | input | NUM_UNITS | Write request, one bit per unit |
| wr_addr | input | NUM_UNITS*ADDR_W | Write address per unit, packed |
| wr_data | input | NUM_UNITS*DATA_W | Write data per unit, packed |
| wr_ack | output | NUM_UNITS | One-hot write grant per unit |
| rf_wr_en | output | 1 | Write enable to the register file |
| rf_wr_addr | output | ADDR_W | Write address to the register file |
| rf_wr_data | output | DATA_W | Write data to the register file |

## Verification
The bench sweeps every write request pattern of four units. A picker that favours the highest index, or a chain that misses one link, would grant the wrong unit or two units at once, and the wrong address and data would then reach the write port. An idle write channel is checked for zero address and data, because a mux that defaults to unit 0 would leak that unit's bus while the enable is low. A two-cycle retry and a simultaneous read-and-write scenario expose grants that stick across cycles or that bleed between channels. A second instance with one unit confirms that the degenerate build passes requests straight through.

// File: rtl/rpa_pkg.sv
// Shared constants for the register port arbiter.
// Assumes: consumers check their unit count against MAX_UNITS.
package rpa_pkg;
    // Largest number of contending units one arbiter serves.
    localparam int MAX_UNITS = 8;
    // Smallest supported address width.
    localparam int MIN_ADDR_W = 1;
endpackage

// File: rtl/rpa_prio_pick.sv
// Fixed-priority picker: grants the lowest-index active request.
// Assumes: purely combinational; clk/rst_n only qualify the checks.
module rpa_prio_pick #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any_o
);
    generate
        if (N == 1) begin : g_single
            // R9: one unit, request passes straight through
            assign grant = req;
        end else begin : g_chain
            logic [N-1:0] blocked;
            // Lowest index is never blocked.
            assign blocked[0] = 1'b0;
            for (genvar i = 1; i < N; i++) begin : g_blk
                // A unit is blocked when any lower unit requests.
                assign blocked[i] = blocked[i-1] | req[i-1];
            end
            // Grant the unblocked requester.
            assign grant = req & ~blocked;
        end
    endgenerate

    // Any request at all on this channel.
    assign any_o = |req;

    // R1
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & ~req) == '0));

    // R2
    lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |-> ((req & (grant - N'(1))) == '0));

    // R3
    req_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> $onehot(grant));
endmodule

// File: rtl/rpa_onehot_mux.sv
// AND-OR selector: folds N packed lanes onto one bus using a one-hot select.
// Assumes: sel is one-hot or zero; zero select yields an all-zero output.
module rpa_onehot_mux #(
    parameter int N = 4,
    parameter int W = 8
) (
    input  logic [N-1:0]   sel,
    input  logic [N*W-1:0] din,
    output logic [W-1:0]   dout
);
    // OR together every lane masked by its select bit.
    always_comb begin
        dout = '0;
        for (int i = 0; i < N; i++) begin
            dout = dout | (din[i*W +: W] & {W{sel[i]}});
        end
    end
endmodule

// File: rtl/rpa_rd_fanout.sv
// Read channel: picks one unit, steers its address to the register file,
// broadcasts the returned data to all units and qualifies only the winner.
// Assumes: register file read data returns combinationally in the same cycle.
module rpa_rd_fanout #(
    parameter int N      = 4,
    parameter int DATA_W = 64,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      fu_req,
    input  logic [N*ADDR_W-1:0] fu_addr,
    output logic [N*DATA_W-1:0] fu_data,
    output logic [N-1:0]      fu_valid,
    output logic              rf_en,
    output logic [ADDR_W-1:0] rf_addr,
    input  logic [DATA_W-1:0] rf_data
);
    logic [N-1:0] grant;
    logic         any_req;

    rpa_prio_pick #(.N(N)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (fu_req),
        .grant (grant),
        .any_o (any_req)
    );

    rpa_onehot_mux #(.N(N), .W(ADDR_W)) u_addr_mux (
        .sel  (grant),
        .din  (fu_addr),
        .dout (rf_addr)
    );

    // Drive the register file read enable from any request.
    assign rf_en    = any_req;
    // Data-valid per unit follows its grant.
    assign fu_valid = grant;

    generate
        for (genvar i = 0; i < N; i++) begin : g_bcast
            // R4: every unit sees the same register data
            assign fu_data[i*DATA_W +: DATA_W] = rf_data;
        end
    endgenerate

    // R5
    rd_valid_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fu_valid & ~fu_req) == '0);

    // R6
    rd_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_en == (fu_req != '0));
endmodule

// File: rtl/rpa_wr_fanin.sv
// Write channel: picks one unit and folds its address and data onto the
// single register file write port, acknowledging only the winner.
// Assumes: the register file commits on rf_en at its own clock edge.
module rpa_wr_fanin #(
    parameter int N      = 4,
    parameter int DATA_W = 64,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      fu_req,
    input  logic [N*ADDR_W-1:0] fu_addr,
    input  logic [N*DATA_W-1:0] fu_data,
    output logic [N-1:0]      fu_ack,
    output logic              rf_en,
    output logic [ADDR_W-1:0] rf_addr,
    output logic [DATA_W-1:0] rf_data
);
    logic [N-1:0] grant;
    logic         any_req;

    rpa_prio_pick #(.N(N)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (fu_req),
        .grant (grant),
        .any_o (any_req)
    );

    rpa_onehot_mux #(.N(N), .W(ADDR_W)) u_addr_mux (
        .sel  (grant),
        .din  (fu_addr),
        .dout (rf_addr)
    );

    rpa_onehot_mux #(.N(N), .W(DATA_W)) u_data_mux (
        .sel  (grant),
        .din  (fu_data),
        .dout (rf_data)
    );

    // Write enable is raised only when some unit holds the grant.
    assign rf_en  = any_req;
    // Acknowledge follows the grant.
    assign fu_ack = grant;

    // R7
    wr_en_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_en |-> $onehot(fu_ack));

    // R8
    wr_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fu_req == '0) |-> (!rf_en && rf_addr == '0 && rf_data == '0));
endmodule

// File: rtl/regport_arbiter.sv
// Register port arbiter top: one read-port channel and one write-port
// channel of a register file, each shared by NUM_UNITS function units.
// Assumes: no state; the channels arbitrate independently (R10).
module regport_arbiter #(
    parameter int NUM_UNITS = 4,
    parameter int DATA_W    = 64,
    parameter int ADDR_W    = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_UNITS-1:0]        rd_req,
    input  logic [NUM_UNITS*ADDR_W-1:0] rd_addr,
    output logic [NUM_UNITS*DATA_W-1:0] rd_data_fu,
    output logic [NUM_UNITS-1:0]        rd_valid,
    output logic                        rf_rd_en,
    output logic [ADDR_W-1:0]           rf_rd_addr,
    input  logic [DATA_W-1:0]           rf_rd_data,
    input  logic [NUM_UNITS-1:0]        wr_req,
    input  logic [NUM_UNITS*ADDR_W-1:0] wr_addr,
    input  logic [NUM_UNITS*DATA_W-1:0] wr_data,
    output logic [NUM_UNITS-1:0]        wr_ack,
    output logic                        rf_wr_en,
    output logic [ADDR_W-1:0]           rf_wr_addr,
    output logic [DATA_W-1:0]           rf_wr_data
);
    localparam int UNITS_OK = (NUM_UNITS >= 1 && NUM_UNITS <= rpa_pkg::MAX_UNITS) ? 1 : 0;
    localparam int ADDR_OK  = (ADDR_W >= rpa_pkg::MIN_ADDR_W) ? 1 : 0;

    generate
        if (UNITS_OK == 0 || ADDR_OK == 0) begin : g_bad_cfg
            $error("regport_arbiter: unsupported NUM_UNITS or ADDR_W");
        end
    endgenerate

    rpa_rd_fanout #(.N(NUM_UNITS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .fu_req   (rd_req),
        .fu_addr  (rd_addr),
        .fu_data  (rd_data_fu),
        .fu_valid (rd_valid),
        .rf_en    (rf_rd_en),
        .rf_addr  (rf_rd_addr),
        .rf_data  (rf_rd_data)
    );

    rpa_wr_fanin #(.N(NUM_UNITS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_wr (
        .clk     (clk),
        .rst_n   (rst_n),
        .fu_req  (wr_req),
        .fu_addr (wr_addr),
        .fu_data (wr_data),
        .fu_ack  (wr_ack),
        .rf_en   (rf_wr_en),
        .rf_addr (rf_wr_addr),
        .rf_data (rf_wr_data)
    );
endmodule

// File: tb/regport_arbiter_test.sv
`timescale 1ns/1ps
module regport_arbiter_test;
    localparam int N  = 4;
    localparam int DW = 64;
    localparam int AW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic [N-1:0]    rd_req = '0;
    logic [N*AW-1:0] rd_addr;
    logic [N*DW-1:0] rd_data_fu;
    logic [N-1:0]    rd_valid;
    logic            rf_rd_en;
    logic [AW-1:0]   rf_rd_addr;
    logic [DW-1:0]   rf_rd_data = '0;
    logic [N-1:0]    wr_req = '0;
    logic [N*AW-1:0] wr_addr;
    logic [N*DW-1:0] wr_data;
    logic [N-1:0]    wr_ack;
    logic            rf_wr_en;
    logic [AW-1:0]   rf_wr_addr;
    logic [DW-1:0]   rf_wr_data;

    regport_arbiter #(.NUM_UNITS(N), .DATA_W(DW), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_data_fu(rd_data_fu),
        .rd_valid(rd_valid), .rf_rd_en(rf_rd_en), .rf_rd_addr(rf_rd_addr),
        .rf_rd_data(rf_rd_data),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_ack(wr_ack), .rf_wr_en(rf_wr_en), .rf_wr_addr(rf_wr_addr),
        .rf_wr_data(rf_wr_data)
    );

    // Single-unit build.
    logic [0:0]    s_rd_req = '0, s_wr_req = '0;
    logic [AW-1:0] s_rd_addr = 5'd9, s_wr_addr = 5'd22;
    logic [DW-1:0] s_rd_data_fu, s_wr_data = 64'h0123_4567_89AB_CDEF;
    logic [0:0]    s_rd_valid, s_wr_ack;
    logic          s_rf_rd_en, s_rf_wr_en;
    logic [AW-1:0] s_rf_rd_addr, s_rf_wr_addr;
    logic [DW-1:0] s_rf_wr_data;

    regport_arbiter #(.NUM_UNITS(1), .DATA_W(DW), .ADDR_W(AW)) uut_single (
        .clk(clk), .rst_n(rst_n),
        .rd_req(s_rd_req), .rd_addr(s_rd_addr), .rd_data_fu(s_rd_data_fu),
        .rd_valid(s_rd_valid), .rf_rd_en(s_rf_rd_en), .rf_rd_addr(s_rf_rd_addr),
        .rf_rd_data(64'h5555_AAAA_5555_AAAA),
        .wr_req(s_wr_req), .wr_addr(s_wr_addr), .wr_data(s_wr_data),
        .wr_ack(s_wr_ack), .rf_wr_en(s_rf_wr_en), .rf_wr_addr(s_rf_wr_addr),
        .rf_wr_data(s_rf_wr_data)
    );

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    function automatic logic [AW-1:0] raddr_of(int i); return AW'(i*3 + 1);  endfunction
    function automatic logic [AW-1:0] waddr_of(int i); return AW'(i*7 + 2);  endfunction
    function automatic logic [DW-1:0] wdata_of(int i); return 64'hBEEF_0000_0000_0000 + 64'(i*17 + 5); endfunction

    // Index of the lowest set bit, -1 when none.
    function automatic int win_idx(logic [N-1:0] r);
        for (int i = 0; i < N; i++) if (r[i]) return i;
        return -1;
    endfunction

    function automatic logic [N-1:0] onehot_of(int idx);
        return (idx < 0) ? '0 : N'(1) << idx;
    endfunction

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(string tag, logic [63:0] act, logic [63:0] exp);
        chk(act === exp, tag, act, exp);
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    // Reset state with every request low.
    task automatic t_reset();
        rd_req = '0; wr_req = '0;
        settle(); #1;
        chk_eq("R3 rd_valid idle", 64'(rd_valid), 64'h0);
        chk_eq("R6 rf_rd_en idle", 64'(rf_rd_en), 64'h0);
        chk_eq("R3 wr_ack idle", 64'(wr_ack), 64'h0);
        chk_eq("R8 rf_wr_en idle", 64'(rf_wr_en), 64'h0);
        chk_eq("R8 rf_wr_addr idle", 64'(rf_wr_addr), 64'h0);
        chk_eq("R8 rf_wr_data idle", rf_wr_data, 64'h0);
    endtask

    // One reader at a time.
    task automatic t_single_read();
        for (int i = 0; i < N; i++) begin
            settle(); rd_req = onehot_of(i); #1;
            chk_eq("R5 single rd_valid", 64'(rd_valid), 64'(onehot_of(i)));
            chk_eq("R6 single rf_rd_addr", 64'(rf_rd_addr), 64'(raddr_of(i)));
            chk_eq("R6 single rf_rd_en", 64'(rf_rd_en), 64'h1);
        end
        rd_req = '0;
    endtask

    // Several readers contend.
    task automatic t_read_contention();
        logic [N-1:0] pats [4] = '{4'b1111, 4'b1010, 4'b1100, 4'b0110};
        for (int k = 0; k < 4; k++) begin
            settle(); rd_req = pats[k]; #1;
            chk_eq("R2 rd winner", 64'(rd_valid), 64'(onehot_of(win_idx(pats[k]))));
            chk_eq("R1 rd onehot", 64'($countones(rd_valid)), 64'h1);
            chk_eq("R6 rd addr of winner", 64'(rf_rd_addr), 64'(raddr_of(win_idx(pats[k]))));
        end
        rd_req = '0;
    endtask

    // Read data reaches every unit.
    task automatic t_broadcast();
        logic [DW-1:0] vals [3] = '{64'hDEAD_BEEF_0BAD_F00D, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF};
        for (int k = 0; k < 3; k++) begin
            settle(); rf_rd_data = vals[k]; rd_req = 4'b0100; #1;
            for (int i = 0; i < N; i++)
                chk_eq("R4 broadcast copy", rd_data_fu[i*DW +: DW], vals[k]);
        end
        rd_req = '0;
    endtask

    // Every write request pattern.
    task automatic t_write_sweep();
        for (int p = 0; p < (1 << N); p++) begin
            int w;
            settle(); wr_req = N'(p); #1;
            w = win_idx(N'(p));
            chk_eq("R7 wr_ack", 64'(wr_ack), 64'(onehot_of(w)));
            chk_eq("R7 rf_wr_en", 64'(rf_wr_en), 64'(p != 0));
            chk_eq("R7 rf_wr_addr", 64'(rf_wr_addr), (w < 0) ? 64'h0 : 64'(waddr_of(w)));
            chk_eq("R8 rf_wr_data", rf_wr_data, (w < 0) ? 64'h0 : wdata_of(w));
        end
        wr_req = '0;
    endtask

    // Loser retries and wins once the lower unit drops.
    task automatic t_retry();
        settle(); rd_req = 4'b0101; #1;
        chk_eq("R5 retry first cycle", 64'(rd_valid), 64'h1);
        settle(); rd_req = 4'b0100; #1;
        chk_eq("R5 retry second cycle", 64'(rd_valid), 64'h4);
        chk_eq("R5 retry addr", 64'(rf_rd_addr), 64'(raddr_of(2)));
        rd_req = '0;
    endtask

    // Channels do not interact.
    task automatic t_independent();
        settle(); rd_req = 4'b1000; wr_req = 4'b0011; #1;
        chk_eq("R10 rd winner unaffected", 64'(rd_valid), 64'h8);
        chk_eq("R10 wr winner unaffected", 64'(wr_ack), 64'h1);
        settle(); rd_req = 4'b0000; wr_req = 4'b1110; #1;
        chk_eq("R10 rd idle with writes", 64'(rd_valid), 64'h0);
        chk_eq("R10 wr winner", 64'(wr_ack), 64'h2);
        rd_req = '0; wr_req = '0;
    endtask

    // One-unit build passes through.
    task automatic t_single_unit();
        settle(); s_rd_req = 1'b0; s_wr_req = 1'b0; #1;
        chk_eq("R9 single idle rd", 64'(s_rd_valid), 64'h0);
        chk_eq("R9 single idle wr", 64'(s_rf_wr_en), 64'h0);
        settle(); s_rd_req = 1'b1; s_wr_req = 1'b1; #1;
        chk_eq("R9 single rd_valid", 64'(s_rd_valid), 64'h1);
        chk_eq("R9 single rd addr", 64'(s_rf_rd_addr), 64'd9);
        chk_eq("R9 single wr_ack", 64'(s_wr_ack), 64'h1);
        chk_eq("R9 single wr data", s_rf_wr_data, 64'h0123_4567_89AB_CDEF);
        chk_eq("R9 single rd data", s_rd_data_fu, 64'h5555_AAAA_5555_AAAA);
        s_rd_req = 1'b0; s_wr_req = 1'b0;
    endtask

    // Fixed per-unit buses.
    initial begin
        for (int i = 0; i < N; i++) begin
            rd_addr[i*AW +: AW] = raddr_of(i);
            wr_addr[i*AW +: AW] = waddr_of(i);
            wr_data[i*DW +: DW] = wdata_of(i);
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Main sequence.
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_single_read();
        t_read_contention();
        t_broadcast();
        t_write_sweep();
        t_retry();
        t_independent();
        t_single_unit();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule